// File: doc/BRIEF.md
# Machine Counter and Identification CSR Slice

This block is the part of an RV64 hart's control-and-status register file that holds the performance counters and the machine identification registers. It keeps a cycle counter that advances on every clock. It also keeps a retired-instruction counter that advances on a retire pulse. A counter-inhibit register can freeze the retired-instruction counter. Four read-only identification registers complete the slice. The pipeline presents one CSR access per cycle: an address, a read or write request, write data and the current privilege level. The block answers in the same cycle with the read data, the value held before a write, and a flag that marks the access as illegal.

Decode and permission checks are combinational. State changes at the clock edge that ends the access cycle. A legal write to the retired-instruction counter replaces the count and cancels that cycle's increment, so the next read returns exactly the written value. An illegal access changes no state. The pipeline is expected to turn the flag into an illegal-instruction trap.

Top module: `mcnt_csr_slice`

## Requirements
- R1: After reset the cycle counter is 0. It then increases by exactly 1 on every clock, whether or not an access is made. It is read at 0xC00, and 0xC01 returns the same count.
- R2: When the inhibit bit is clear, each cycle with `retire_i` high increases the retired-instruction count by 1. The count reads the same at 0xB02 and at 0xC02, and it is 0 after reset.
- R3: A write to the inhibit register at 0x320 keeps only bit 2 of the written data and clears every other bit. While bit 2 is set, retire pulses leave the retired-instruction count unchanged.
- R4: A legal write to 0xB02 loads the written value. Any increment in that same cycle is dropped, so the next read returns exactly the written value even when `retire_i` was high.
- R5: Addresses 0xF11, 0xF12 and 0xF13 read as 0. Address 0xF14 reads the HART_ID parameter, which defaults to 0. A write to any of these four addresses is illegal.
- R6: Addresses 0xC00 to 0xC02 can be read at every privilege level. A write to any of them is illegal.
- R7: The registers at 0x320, 0xB02 and 0xF11 to 0xF14 are accessible only in machine mode. Privilege encoding: 0 is user, 1 is supervisor, 3 is machine. Any access to these registers at another level is illegal.
- R8: An illegal access raises `illegal_o`, returns 0 on `rdata_o` and `old_data_o`, and changes no state.
- R9: On a legal write, `old_data_o` returns the register value before the write. `old_data_o` is 0 when no write is made.
- R10: An access to an address not listed above is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | A CSR access is presented this cycle |
| acc_write_i | input | 1 | The access is a write (1) or a read (0) |
| acc_addr_i | input | 12 | CSR address |
| acc_wdata_i | input | XLEN | Write data |
| priv_i | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| retire_i | input | 1 | One instruction retires this cycle |
| rdata_o | output | XLEN | Current value of the addressed register; 0 if illegal or idle |
| old_data_o | output | XLEN | Pre-write value during a legal write, else 0 |
| illegal_o | output | 1 | The presented access is illegal |

## Verification
`rdata_o`, `old_data_o` and `illegal_o` are combinational, so they are due in the same cycle as the access. The bench drives each access on the falling edge and samples these outputs 1 ns later, before the rising edge. The effects of a write, a retire pulse or a cycle step are due one rising edge later. The bench therefore checks them with a read in a later cycle, and it counts the exact number of edges between two cycle-counter reads. An illegal access is judged by reading the affected register back through the normal read path in the cycles that follow.

// File: rtl/mcnt_csr_pkg.sv
package mcnt_csr_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [11:0] A_CYCLE_U   = 12'hC00;
    localparam logic [11:0] A_TIME_U    = 12'hC01;
    localparam logic [11:0] A_INSTRET_U = 12'hC02;
    localparam logic [11:0] A_INSTRET_M = 12'hB02;
    localparam logic [11:0] A_INHIBIT   = 12'h320;
    localparam logic [11:0] A_VENDOR    = 12'hF11;
    localparam logic [11:0] A_ARCH      = 12'hF12;
    localparam logic [11:0] A_IMPL      = 12'hF13;
    localparam logic [11:0] A_HART      = 12'hF14;

    localparam int INHIBIT_IR_BIT = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYCLE,
        SEL_INSTRET,
        SEL_INHIBIT,
        SEL_ZERO,
        SEL_HART
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e sel;
        logic     known;
        logic     read_only;
        logic     machine_only;
    } csr_dec_t;

    function automatic csr_dec_t decode_addr(input logic [11:0] a);
        csr_dec_t d;
        d = '{sel: SEL_NONE, known: 1'b0, read_only: 1'b0, machine_only: 1'b0};
        unique case (a)
            A_CYCLE_U, A_TIME_U: d = '{SEL_CYCLE, 1'b1, 1'b1, 1'b0};
            A_INSTRET_U:         d = '{SEL_INSTRET, 1'b1, 1'b1, 1'b0};
            A_INSTRET_M:         d = '{SEL_INSTRET, 1'b1, 1'b0, 1'b1};
            A_INHIBIT:           d = '{SEL_INHIBIT, 1'b1, 1'b0, 1'b1};
            A_VENDOR, A_ARCH, A_IMPL: d = '{SEL_ZERO, 1'b1, 1'b1, 1'b1};
            A_HART:              d = '{SEL_HART, 1'b1, 1'b1, 1'b1};
            default:             d = '{SEL_NONE, 1'b0, 1'b0, 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mcnt_csr_decode.sv
module mcnt_csr_decode
    import mcnt_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  logic        write_i,
    input  logic [11:0] addr_i,
    input  logic [1:0]  priv_i,
    output csr_sel_e    sel_o,
    output logic        legal_o,
    output logic        illegal_o
);

    csr_dec_t dec;
    logic     deny;

    always_comb begin
        dec       = decode_addr(addr_i);
        deny      = !dec.known
                  || (dec.machine_only && priv_i != PRIV_M)
                  || (write_i && dec.read_only);
        sel_o     = dec.sel;
        illegal_o = valid_i && deny;
        legal_o   = valid_i && !deny;
    end

    AST_ID_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (valid_i && write_i && addr_i[11:4] == 8'hF1 && addr_i[3:0] >= 4'h1 && addr_i[3:0] <= 4'h4)
        |-> illegal_o); // R5
    AST_ALIAS_WRITE_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (valid_i && write_i && addr_i[11:2] == 10'b1100_0000_00 && addr_i[1:0] != 2'b11)
        |-> illegal_o); // R6
    AST_MACHINE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (valid_i && priv_i != PRIV_M && addr_i[9:8] == 2'b11) |-> illegal_o); // R7
    AST_EXCLUSIVE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !(legal_o && illegal_o)); // R8

endmodule

// File: rtl/mcnt_csr_counters.sv
module mcnt_csr_counters
    import mcnt_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_instret_i,
    input  logic            wr_inhibit_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            retire_i,
    output logic [XLEN-1:0] cycle_o,
    output logic [XLEN-1:0] instret_o,
    output logic [XLEN-1:0] inhibit_o
);

    localparam logic [XLEN-1:0] IR_MASK = XLEN'(1) << INHIBIT_IR_BIT;

    logic [XLEN-1:0] cycle_q, instret_q, inhibit_q;
    logic            past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cycle_q   <= '0;
            instret_q <= '0;
            inhibit_q <= '0;
            past_ok   <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            cycle_q <= cycle_q + 1'b1;
            if (wr_instret_i)
                instret_q <= wdata_i;
            else if (retire_i && !inhibit_q[INHIBIT_IR_BIT])
                instret_q <= instret_q + 1'b1;
            if (wr_inhibit_i)
                inhibit_q <= wdata_i & IR_MASK;
        end
    end

    assign cycle_o   = cycle_q;
    assign instret_o = instret_q;
    assign inhibit_o = inhibit_q;

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> cycle_q == $past(cycle_q) + 1'b1); // R1
    AST_INSTRET_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (inhibit_q[INHIBIT_IR_BIT] && !wr_instret_i) |=> $stable(instret_q)); // R3
    AST_INHIBIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_inhibit_i |=> inhibit_q == ($past(wdata_i) & IR_MASK)); // R3
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_instret_i |=> instret_q == $past(wdata_i)); // R4
    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_inhibit_i |=> $stable(inhibit_q)); // R8

endmodule

// File: rtl/mcnt_csr_slice.sv
module mcnt_csr_slice
    import mcnt_csr_pkg::*;
#(
    parameter int          XLEN    = 64,
    parameter logic [63:0] HART_ID = 64'd0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid_i,
    input  logic            acc_write_i,
    input  logic [11:0]     acc_addr_i,
    input  logic [XLEN-1:0] acc_wdata_i,
    input  logic [1:0]      priv_i,
    input  logic            retire_i,
    output logic [XLEN-1:0] rdata_o,
    output logic [XLEN-1:0] old_data_o,
    output logic            illegal_o
);

    csr_sel_e        sel;
    logic            legal;
    logic            wr_instret, wr_inhibit;
    logic [XLEN-1:0] cycle_v, instret_v, inhibit_v, value;

    mcnt_csr_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (acc_valid_i),
        .write_i   (acc_write_i),
        .addr_i    (acc_addr_i),
        .priv_i    (priv_i),
        .sel_o     (sel),
        .legal_o   (legal),
        .illegal_o (illegal_o)
    );

    assign wr_instret = legal && acc_write_i && sel == SEL_INSTRET;
    assign wr_inhibit = legal && acc_write_i && sel == SEL_INHIBIT;

    mcnt_csr_counters #(.XLEN(XLEN)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .wr_instret_i (wr_instret),
        .wr_inhibit_i (wr_inhibit),
        .wdata_i      (acc_wdata_i),
        .retire_i     (retire_i),
        .cycle_o      (cycle_v),
        .instret_o    (instret_v),
        .inhibit_o    (inhibit_v)
    );

    always_comb begin
        unique case (sel)
            SEL_CYCLE:   value = cycle_v;
            SEL_INSTRET: value = instret_v;
            SEL_INHIBIT: value = inhibit_v;
            SEL_HART:    value = XLEN'(HART_ID);
            default:     value = '0;
        endcase
        rdata_o    = legal ? value : '0;
        old_data_o = (legal && acc_write_i) ? value : '0;
    end

    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (rdata_o == '0 && old_data_o == '0)); // R8
    AST_ILLEGAL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (illegal_o && !retire_i) |=> $stable(instret_v)); // R8
    AST_OLD_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (acc_write_i && !illegal_o) |-> old_data_o == rdata_o); // R9

endmodule

// File: tb/mcnt_csr_slice_tb_top.sv
module mcnt_csr_slice_tb_top;

    localparam int          XLEN = 64;
    localparam logic [63:0] HID  = 64'd5;

    logic            clk = 1'b0;
    logic            rst;
    logic            v, w, ret;
    logic [11:0]     a;
    logic [XLEN-1:0] wd;
    logic [1:0]      p;
    logic [XLEN-1:0] rdata, old;
    logic            ill;

    logic [XLEN-1:0] s_rd, s_old;
    logic            s_ill;

    int compared = 0;
    int mismatched = 0;
    logic [XLEN-1:0] t1, t2;

    always #2 clk = ~clk;

    mcnt_csr_slice #(.XLEN(XLEN), .HART_ID(HID)) dut_i (
        .clk(clk), .rst(rst), .acc_valid_i(v), .acc_write_i(w), .acc_addr_i(a),
        .acc_wdata_i(wd), .priv_i(p), .retire_i(ret),
        .rdata_o(rdata), .old_data_o(old), .illegal_o(ill)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  pr;
        logic [11:0] ad;
        logic        exp_ill;
        logic        chk_rd;
        logic [63:0] exp_rd;
    } vec_t;

    localparam vec_t VECS [0:10] = '{
        '{1'b0, 2'd3, 12'hF11, 1'b0, 1'b1, 64'd0},  // R5
        '{1'b0, 2'd3, 12'hF12, 1'b0, 1'b1, 64'd0},  // R5
        '{1'b0, 2'd3, 12'hF13, 1'b0, 1'b1, 64'd0},  // R5
        '{1'b0, 2'd3, 12'hF14, 1'b0, 1'b1, 64'd5},  // R5
        '{1'b1, 2'd3, 12'hF14, 1'b1, 1'b1, 64'd0},  // R5
        '{1'b1, 2'd3, 12'hC00, 1'b1, 1'b1, 64'd0},  // R6
        '{1'b1, 2'd3, 12'hC02, 1'b1, 1'b1, 64'd0},  // R6
        '{1'b0, 2'd0, 12'hC02, 1'b0, 1'b0, 64'd0},  // R6
        '{1'b0, 2'd1, 12'hF12, 1'b1, 1'b1, 64'd0},  // R7
        '{1'b0, 2'd1, 12'h320, 1'b1, 1'b1, 64'd0},  // R7
        '{1'b0, 2'd3, 12'h123, 1'b1, 1'b1, 64'd0}   // R10
    };

    task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic vv, input logic ww, input logic [1:0] pp,
                          input logic [11:0] aa, input logic [XLEN-1:0] dd, input logic rr);
        @(negedge clk);
        v = vv; w = ww; p = pp; a = aa; wd = dd; ret = rr;
        #1;
        s_rd = rdata; s_old = old; s_ill = ill;
        @(posedge clk);
    endtask

    task automatic rd(input logic [11:0] aa);
        access(1'b1, 1'b0, 2'd3, aa, '0, 1'b0);
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        v = 0; w = 0; p = 2'd3; a = '0; wd = '0; ret = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // Reset state
        rd(12'hB02); check("R2 reset instret", s_rd, 64'd0);
        rd(12'h320); check("R3 reset inhibit", s_rd, 64'd0);

        // Vector table
        for (int i = 0; i < 11; i++) begin
            access(1'b1, VECS[i].wr, VECS[i].pr, VECS[i].ad, 64'hFFFF, 1'b0);
            check("R7/R10 vector illegal", {63'd0, s_ill}, {63'd0, VECS[i].exp_ill});
            if (VECS[i].chk_rd) check("R5/R8 vector rdata", s_rd, VECS[i].exp_rd);
        end

        // R1 cycle stepping
        rd(12'hC00); t1 = s_rd;
        rd(12'hC00); t2 = s_rd;
        check("R1 cycle step", t2, t1 + 1);
        rd(12'hC01); check("R1 time alias", s_rd, t2 + 1);
        access(1'b0, 1'b0, 2'd3, '0, '0, 1'b0);
        access(1'b0, 1'b0, 2'd3, '0, '0, 1'b0);
        rd(12'hC00); check("R1 idle cycles", s_rd, t2 + 4);

        // R2 retire counting
        repeat (3) access(1'b0, 1'b0, 2'd3, '0, '0, 1'b1);
        rd(12'hB02); check("R2 instret", s_rd, 64'd3);
        access(1'b1, 1'b0, 2'd0, 12'hC02, '0, 1'b0); check("R2 user alias", s_rd, 64'd3);

        // R4 / R9 write with simultaneous retire
        access(1'b1, 1'b1, 2'd3, 12'hB02, 64'd100, 1'b1);
        check("R9 old value", s_old, 64'd3);
        check("R4 write legal", {63'd0, s_ill}, 64'd0);
        rd(12'hB02); check("R4 write suppresses increment", s_rd, 64'd100);

        // R3 inhibit
        access(1'b1, 1'b1, 2'd3, 12'h320, '1, 1'b0);
        rd(12'h320); check("R3 only bit 2 kept", s_rd, 64'd4);
        repeat (2) access(1'b0, 1'b0, 2'd3, '0, '0, 1'b1);
        rd(12'hB02); check("R3 inhibited count", s_rd, 64'd100);
        access(1'b1, 1'b1, 2'd3, 12'h320, 64'hFB, 1'b0);
        check("R9 old inhibit", s_old, 64'd4);
        rd(12'h320); check("R3 inhibit cleared", s_rd, 64'd0);
        access(1'b0, 1'b0, 2'd3, '0, '0, 1'b1);
        rd(12'hB02); check("R2 counting resumes", s_rd, 64'd101);

        // R8 illegal writes leave state
        access(1'b1, 1'b1, 2'd1, 12'hB02, 64'd7, 1'b0);
        check("R8 flag", {63'd0, s_ill}, 64'd1);
        check("R8 old zero", s_old, 64'd0);
        access(1'b1, 1'b1, 2'd0, 12'h320, 64'd4, 1'b0);
        access(1'b1, 1'b1, 2'd3, 12'hC02, 64'd9, 1'b0);
        rd(12'hB02); check("R8 instret kept", s_rd, 64'd101);
        rd(12'h320); check("R8 inhibit kept", s_rd, 64'd0);
        rd(12'hF11); check("R9 no write old zero", s_old, 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule